// File: doc/BRIEF.md
# Single-cycle load-word datapath

This block is a 32-bit processor datapath that completes one load-word instruction in every clock cycle. The program counter addresses a small instruction store. The fetched word is split into its opcode, base-register, destination-register and immediate fields. The base register's value and the sign-extended 16-bit immediate go through an adder-driven ALU to form a byte address, and the data store returns the addressed word. On the next rising edge that word is written into the destination register and the program counter moves forward by four. No other instruction is executed: a word with any other opcode is fetched, decoded and its address is still formed, but no register changes.

Both stores are small word arrays with a combinational read and a clocked write. They are filled through a single preload port before the datapath is released from reset. Through its outputs the block shows the current program counter, the fetched instruction, the computed address, the loaded word, the writeback strobe and target, and the present contents of the register named by the destination field. A testbench can therefore watch every stage of the path and the register file itself.

Top module: `lw_datapath`

## Requirements
- R1: While `rst` is high (sampled on a rising edge) the program counter becomes 0, every register becomes 0 and `wb_en` stays low.
- R2: Out of reset, `pc` grows by exactly 4 on every rising edge, modulo 2^32.
- R3: `instr` is the store word whose index is `pc[2+:log2(MEM_WORDS)]`. The two low bits and the bits above the index are ignored, so the store wraps.
- R4: The instruction fields are opcode `[31:26]`, base register `[25:21]`, destination register `[20:16]` and immediate `[15:0]`. The load-word opcode is `6'b100011`. `wb_reg` carries bits `[20:16]`.
- R5: `mem_addr` equals the base register's value plus the 16-bit immediate sign-extended to 32 bits, modulo 2^32.
- R6: `load_word` is the data-store word at index `mem_addr[2+:log2(MEM_WORDS)]`. The low two bits of the address are ignored.
- R7: `wb_en` is high exactly when the opcode is `6'b100011` and `rst` is low. The loaded word is then written into the destination register on the rising edge. Any other opcode leaves every register unchanged.
- R8: Register 0 always reads as 0, both as a base and on `dest_val`. A load that names it as destination has no effect.
- R9: While `load_en` is high, the rising edge writes `load_data` into word `load_addr` of the data store when `load_dmem` is 1, and into the instruction store when it is 0.
- R10: A register written on one edge shows its new value on `dest_val` and as a base operand from the following cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| load_en | input | 1 | Preload write strobe for one store word |
| load_dmem | input | 1 | Preload target: 1 data store, 0 instruction store |
| load_addr | input | log2(MEM_WORDS) | Word index for the preload write |
| load_data | input | 32 | Word written by the preload |
| pc | output | 32 | Current program counter |
| instr | output | 32 | Instruction fetched at `pc` |
| mem_addr | output | 32 | ALU result: base plus extended offset |
| load_word | output | 32 | Data-store word read at `mem_addr` |
| wb_en | output | 1 | Register write strobe for this cycle |
| wb_reg | output | 5 | Register index the writeback targets |
| dest_val | output | 32 | Present contents of the register named by bits [20:16] |

## Verification
The bench runs a generated program of 64 words twice, once per data pattern, with a reset between the runs. Every cycle it predicts the address, loaded word, strobe and register contents from its own register model. Immediates include negative values and low address bits that are not aligned, so a design that zero-extended the offset or used the byte address as a word index would show a wrong `mem_addr` or `load_word`. The program loads into register 0 and then uses register 0 as a base; a design that stored into it would return an offset by the loaded word. Interleaved non-load opcodes target registers that are read later, so a decoder that wrote on every opcode would corrupt a later base. The second run starts on registers that must read zero again, which exposes a reset that leaves the register file alone.

// File: rtl/lw_dp_pkg.sv
package lw_dp_pkg;

    localparam int XLEN      = 32;
    localparam int REG_COUNT = 32;
    localparam int RIDX_W    = $clog2(REG_COUNT);
    localparam int IMM_W     = 16;
    localparam int PC_STEP   = 4;

    localparam logic [5:0] OP_LOAD_WORD = 6'b100011;

    typedef enum logic [2:0] {
        ALU_AND = 3'b000,
        ALU_OR  = 3'b001,
        ALU_ADD = 3'b010,
        ALU_SUB = 3'b110,
        ALU_SLT = 3'b111
    } alu_op_e;

    typedef struct packed {
        logic [5:0]        opcode;
        logic [RIDX_W-1:0] base;
        logic [RIDX_W-1:0] dest;
        logic [IMM_W-1:0]  imm;
    } instr_fields_t;

    typedef struct packed {
        logic              reg_write;
        alu_op_e           alu_op;
        logic [RIDX_W-1:0] base;
        logic [RIDX_W-1:0] dest;
        logic [XLEN-1:0]   offset;
    } lw_ctrl_t;

    function automatic logic [XLEN-1:0] sext_imm(input logic [IMM_W-1:0] v);
        return {{(XLEN-IMM_W){v[IMM_W-1]}}, v};
    endfunction

endpackage

// File: rtl/lw_pc_reg.sv
module lw_pc_reg
    import lw_dp_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    output logic [XLEN-1:0] pc
);
    logic [XLEN-1:0] pc_next;

    always_comb pc_next = pc + XLEN'(PC_STEP);

    always_ff @(posedge clk) begin
        if (rst) pc <= '0;
        else     pc <= pc_next;
    end
endmodule

// File: rtl/lw_word_mem.sv
module lw_word_mem
    import lw_dp_pkg::*;
#(
    parameter int  WORDS = 64,
    localparam int AW    = $clog2(WORDS)
) (
    input  logic            clk,
    input  logic            we,
    input  logic [AW-1:0]   waddr,
    input  logic [XLEN-1:0] wdata,
    input  logic [AW-1:0]   raddr,
    output logic [XLEN-1:0] rdata
);
    logic [XLEN-1:0] cells [WORDS];

    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/lw_regfile.sv
module lw_regfile
    import lw_dp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [RIDX_W-1:0] rd_a_idx,
    output logic [XLEN-1:0]   rd_a_val,
    input  logic [RIDX_W-1:0] rd_b_idx,
    output logic [XLEN-1:0]   rd_b_val,
    input  logic              wr_en,
    input  logic [RIDX_W-1:0] wr_idx,
    input  logic [XLEN-1:0]   wr_val
);
    logic [XLEN-1:0] bank [REG_COUNT];

    for (genvar g = 0; g < REG_COUNT; g++) begin : g_reg
        if (g == 0) begin : g_zero
            always_ff @(posedge clk) bank[g] <= '0;
        end else begin : g_live
            always_ff @(posedge clk) begin
                if (rst)                             bank[g] <= '0;
                else if (wr_en && wr_idx == RIDX_W'(g)) bank[g] <= wr_val;
            end
        end
    end

    always_comb begin
        rd_a_val = (rd_a_idx == '0) ? '0 : bank[rd_a_idx];
        rd_b_val = (rd_b_idx == '0) ? '0 : bank[rd_b_idx];
    end
endmodule

// File: rtl/lw_decode.sv
module lw_decode
    import lw_dp_pkg::*;
(
    input  logic [XLEN-1:0] instr,
    output lw_ctrl_t        ctrl
);
    instr_fields_t f;

    always_comb begin
        f              = instr_fields_t'(instr);
        ctrl.reg_write = (f.opcode == OP_LOAD_WORD);
        ctrl.alu_op    = ALU_ADD;
        ctrl.base      = f.base;
        ctrl.dest      = f.dest;
        ctrl.offset    = sext_imm(f.imm);
    end
endmodule

// File: rtl/lw_alu.sv
module lw_alu
    import lw_dp_pkg::*;
(
    input  alu_op_e         op,
    input  logic [XLEN-1:0] src_a,
    input  logic [XLEN-1:0] src_b,
    output logic [XLEN-1:0] result
);
    always_comb begin
        case (op)
            ALU_AND: result = src_a & src_b;
            ALU_OR:  result = src_a | src_b;
            ALU_SUB: result = src_a - src_b;
            ALU_SLT: result = {{(XLEN-1){1'b0}}, $signed(src_a) < $signed(src_b)};
            default: result = src_a + src_b;
        endcase
    end
endmodule

// File: rtl/lw_datapath.sv
module lw_datapath
    import lw_dp_pkg::*;
#(
    parameter int  MEM_WORDS = 64,
    localparam int MAW       = $clog2(MEM_WORDS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_en,
    input  logic              load_dmem,
    input  logic [MAW-1:0]    load_addr,
    input  logic [XLEN-1:0]   load_data,
    output logic [XLEN-1:0]   pc,
    output logic [XLEN-1:0]   instr,
    output logic [XLEN-1:0]   mem_addr,
    output logic [XLEN-1:0]   load_word,
    output logic              wb_en,
    output logic [RIDX_W-1:0] wb_reg,
    output logic [XLEN-1:0]   dest_val
);
    lw_ctrl_t        ctrl;
    logic [XLEN-1:0] base_val;
    logic            rf_we;

    lw_pc_reg u_pc (
        .clk (clk),
        .rst (rst),
        .pc  (pc)
    );

    lw_word_mem #(.WORDS(MEM_WORDS)) u_imem (
        .clk   (clk),
        .we    (load_en & ~load_dmem),
        .waddr (load_addr),
        .wdata (load_data),
        .raddr (pc[2 +: MAW]),
        .rdata (instr)
    );

    lw_decode u_dec (
        .instr (instr),
        .ctrl  (ctrl)
    );

    lw_regfile u_rf (
        .clk      (clk),
        .rst      (rst),
        .rd_a_idx (ctrl.base),
        .rd_a_val (base_val),
        .rd_b_idx (ctrl.dest),
        .rd_b_val (dest_val),
        .wr_en    (rf_we),
        .wr_idx   (ctrl.dest),
        .wr_val   (load_word)
    );

    lw_alu u_alu (
        .op     (ctrl.alu_op),
        .src_a  (base_val),
        .src_b  (ctrl.offset),
        .result (mem_addr)
    );

    lw_word_mem #(.WORDS(MEM_WORDS)) u_dmem (
        .clk   (clk),
        .we    (load_en & load_dmem),
        .waddr (load_addr),
        .wdata (load_data),
        .raddr (mem_addr[2 +: MAW]),
        .rdata (load_word)
    );

    assign rf_we  = ctrl.reg_write & ~rst;
    assign wb_en  = rf_we;
    assign wb_reg = ctrl.dest;
endmodule

// File: rtl/lw_datapath_chk.sv
module lw_datapath_chk
    import lw_dp_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [XLEN-1:0]   pc,
    input logic [XLEN-1:0]   instr,
    input logic [XLEN-1:0]   mem_addr,
    input logic [XLEN-1:0]   load_word,
    input logic              wb_en,
    input logic [RIDX_W-1:0] wb_reg,
    input logic [XLEN-1:0]   dest_val
);
    p_reset_pc_r1: assert property (@(posedge clk) rst |=> pc == '0);

    p_reset_nowb_r1: assert property (@(posedge clk) rst |-> !wb_en);

    p_pc_step_r2: assert property (@(posedge clk) disable iff (rst)
        !rst |=> pc == $past(pc) + XLEN'(PC_STEP));

    p_wb_target_r4: assert property (@(posedge clk) disable iff (rst)
        wb_en |-> wb_reg == instr[20:16]);

    p_wb_opcode_r7: assert property (@(posedge clk) disable iff (rst)
        wb_en |-> instr[31:26] == OP_LOAD_WORD);

    p_zero_base_r8: assert property (@(posedge clk) disable iff (rst)
        instr[25:21] == '0 |-> mem_addr == sext_imm(instr[15:0]));

    p_zero_dest_r8: assert property (@(posedge clk) disable iff (rst)
        instr[20:16] == '0 |-> dest_val == '0);

    p_raw_r10: assert property (@(posedge clk) disable iff (rst)
        (wb_en && wb_reg != '0) |=>
            (instr[20:16] != $past(wb_reg) || dest_val == $past(load_word)));
endmodule

bind lw_datapath lw_datapath_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .pc        (pc),
    .instr     (instr),
    .mem_addr  (mem_addr),
    .load_word (load_word),
    .wb_en     (wb_en),
    .wb_reg    (wb_reg),
    .dest_val  (dest_val)
);

// File: tb/lw_datapath_test.sv
`timescale 1ns/1ps
module lw_datapath_test;
    localparam int WORDS = 64;
    localparam int AW    = 6;
    localparam int RUN   = 150;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          load_en = 1'b0;
    logic          load_dmem = 1'b0;
    logic [AW-1:0] load_addr = '0;
    logic [31:0]   load_data = '0;
    logic [31:0]   pc, instr, mem_addr, load_word, dest_val;
    logic          wb_en;
    logic [4:0]    wb_reg;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [31:0] m_imem [WORDS];
    logic [31:0] m_dmem [WORDS];
    logic [31:0] m_regs [32];

    always #10 clk = ~clk;

    lw_datapath #(.MEM_WORDS(WORDS)) uut (
        .clk(clk), .rst(rst), .load_en(load_en), .load_dmem(load_dmem),
        .load_addr(load_addr), .load_data(load_data), .pc(pc), .instr(instr),
        .mem_addr(mem_addr), .load_word(load_word), .wb_en(wb_en),
        .wb_reg(wb_reg), .dest_val(dest_val)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] prog_word(input int i);
        logic [5:0]  op;
        logic [4:0]  rs, rt;
        logic [15:0] imm;
        op  = 6'b100011;
        rs  = 5'((i * 7) % 32);
        rt  = 5'((i * 11 + 3) % 32);
        imm = 16'((i * 1237 + 3) % 65536);
        if (i == 0)      begin rs = 5'd0; rt = 5'd0; imm = 16'd4;      end
        else if (i == 1) begin rs = 5'd0; rt = 5'd7; imm = 16'hFFF8;   end
        else if (i == 2) begin op = 6'b000000; rs = 5'd0; rt = 5'd7;   end
        else if (i == 3) begin rs = 5'd0; rt = 5'd9; imm = 16'd13;     end
        else if (i == 4) begin rs = 5'd9; rt = 5'd10; imm = 16'hFFFF;  end
        else if (i % 9 == 5) op = 6'b101011;
        return {op, rs, rt, imm};
    endfunction

    function automatic logic [31:0] data_word(input int j, input int phase);
        return (32'(j) * 32'h0104_0A13) ^ (phase == 0 ? 32'h8000_0004 : 32'h1357_9BDF);
    endfunction

    task automatic preload(input int phase);
        for (int j = 0; j < WORDS; j++) begin
            m_imem[j] = prog_word(j);
            m_dmem[j] = data_word(j, phase);
        end
        for (int j = 0; j < 2 * WORDS; j++) begin
            @(negedge clk);
            load_en   = 1'b1;
            load_dmem = (j >= WORDS);
            load_addr = AW'(j % WORDS);
            load_data = (j >= WORDS) ? m_dmem[j - WORDS] : m_imem[j];
        end
        @(negedge clk);
        load_en = 1'b0;
    endtask

    task automatic run_phase(input int phase);
        logic [31:0] pc_exp, ins, bval, addr, data, dval;
        logic [4:0]  rs, rt;
        logic        we;
        rst = 1'b1;
        preload(phase);
        #1;
        chk("R1 pc in reset", pc, 32'h0);
        chk("R1 wb_en in reset", {31'h0, wb_en}, 32'h0);
        for (int r = 0; r < 32; r++) m_regs[r] = 32'h0;
        @(negedge clk);
        rst = 1'b0;
        #1;
        pc_exp = 32'h0;
        for (int c = 0; c < RUN; c++) begin
            ins  = m_imem[pc_exp[2 +: AW]];
            rs   = ins[25:21];
            rt   = ins[20:16];
            bval = (rs == 5'd0) ? 32'h0 : m_regs[rs];
            addr = bval + {{16{ins[15]}}, ins[15:0]};
            data = m_dmem[addr[2 +: AW]];
            we   = (ins[31:26] == 6'b100011);
            dval = (rt == 5'd0) ? 32'h0 : m_regs[rt];
            chk("R2 pc step", pc, pc_exp);
            if (c == 0) chk("R9 preloaded instruction", instr, ins);
            else        chk("R3 fetch", instr, ins);
            chk("R5 address", mem_addr, addr);
            if (c == 0) chk("R9 preloaded data", load_word, data);
            else        chk("R6 load word", load_word, data);
            chk("R7 writeback strobe", {31'h0, wb_en}, {31'h0, we});
            if (we) chk("R4 dest field", {27'h0, wb_reg}, {27'h0, rt});
            if (rt == 5'd0) chk("R8 zero register", dest_val, 32'h0);
            else if (c < 40 || phase == 0) chk("R10 register contents", dest_val, dval);
            else chk("R1 R10 register contents", dest_val, dval);
            if (we && rt != 5'd0) m_regs[rt] = data;
            pc_exp = pc_exp + 32'd4;
            @(negedge clk);
            #1;
        end
    endtask

    initial begin
        run_phase(0);
        run_phase(1);
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #2000000;
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule